// File: doc/BRIEF.md
# Dispatch Group Former

This block looks at an in-order window of up to six decoded instructions, each carrying a small class code. Every cycle it picks a group from the front of that window. The group holds up to four non-branch instructions and up to two branches. The block decides how many instructions the group takes and which of six slots each one fills. Slots 0 to 3 take non-branch work and slots 4 and 5 take branches.

Some classes restrict where they may go. A pinned instruction must land in slot 0. A two-slot cracked instruction fills slots 0 and 1 together. A four-slot cracked instruction fills every non-branch slot. A branch does not close the group on its own, but the branch that takes the last branch slot does. An instruction that cannot be placed ends the group and waits for the next cycle, and nothing behind it may overtake it.

The upstream stage uses the combinational consumed count, `take_cnt`, to advance its window in the same cycle. The group descriptor is registered and shows one clock later: a valid flag, the group size, and a valid bit plus a window index for each slot.

Top module: `dispatch_group_former`

## Requirements
- R1: While reset is asserted and after it is released, before any group forms, `grp_vld` is 0, `grp_size` is 0 and `grp_slot_vld` is all zeros.
- R2: When `out_ready` is 0, `take_cnt` is 0 in that cycle and `grp_vld` is 0 after the next clock edge.
- R3: `take_cnt` equals the length of the longest accepted prefix of the window. The prefix stops at the first entry whose `win_valid` bit is 0, at the first entry that cannot be placed, or right after the group closes. No later entry is taken past a stopped one.
- R4: Class 0 (plain) fills the lowest free slot among 0 to 3 in program order. A fifth plain instruction is not taken.
- R5: Class 4 (branch) fills slot 4 and then slot 5 in program order. Taking the branch into slot 5 closes the group, and a third branch is never taken.
- R6: Class 1 (pinned) is taken only when no non-branch slot is used yet. It fills slot 0.
- R7: Class 2 (pair) is taken only when no non-branch slot is used. It fills slots 0 and 1, with both carrying its window index.
- R8: Class 3 (quad) is taken only when no non-branch slot is used. It fills slots 0 to 3, with all four carrying its window index.
- R9: One clock edge after a cycle with `take_cnt` = N, the descriptor shows `grp_size` = N and `grp_vld` = (N != 0). Each used slot s has `grp_slot_vld[s]` = 1 and window index `grp_slot_idx[3s+2:3s]`. Window entry i has its class in `win_class[3i+2:3i]`.
- R10: Class codes 5, 6 and 7 are placed exactly like class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 6 | Valid bit per window entry, entry 0 oldest |
| win_class | input | 18 | Class code per entry, 3 bits each |
| out_ready | input | 1 | Downstream can accept a group this cycle |
| take_cnt | output | 3 | Entries consumed this cycle (0 to 6), combinational |
| grp_vld | output | 1 | Registered group descriptor is valid |
| grp_size | output | 3 | Registered number of entries in the group |
| grp_slot_vld | output | 6 | Registered per-slot valid, slots 0-3 non-branch, 4-5 branch |
| grp_slot_idx | output | 18 | Registered window index per slot, 3 bits each |

## Verification
`take_cnt` depends only on the current inputs. The bench drives the window on a falling edge and samples the count one nanosecond later, in the same cycle. The descriptor passes through one register. The bench therefore samples it shortly after the next rising edge and compares it with the expected group it computed for the same stimulus. Each stimulus is held for exactly one rising edge, so every descriptor belongs to exactly one window.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

   localparam int CLS_W = 3;

   localparam logic [CLS_W-1:0] CLS_PLAIN  = 3'd0;
   localparam logic [CLS_W-1:0] CLS_HEAD   = 3'd1;
   localparam logic [CLS_W-1:0] CLS_PAIR   = 3'd2;
   localparam logic [CLS_W-1:0] CLS_QUAD   = 3'd3;
   localparam logic [CLS_W-1:0] CLS_BRANCH = 3'd4;

   // placement demand derived from a class code
   typedef enum logic [2:0] {
      DK_ANY  = 3'd0,
      DK_HEAD = 3'd1,
      DK_PAIR = 3'd2,
      DK_ALL  = 3'd3,
      DK_BR   = 3'd4
   } dk_e;

endpackage

// File: rtl/dgf_class_decode.sv
module dgf_class_decode
   import dgf_pkg::*;
(
   input  logic [CLS_W-1:0] cls_i,
   output dk_e              kind_o
);

   always_comb begin
      case (cls_i)
         CLS_HEAD:   kind_o = DK_HEAD;
         CLS_PAIR:   kind_o = DK_PAIR;
         CLS_QUAD:   kind_o = DK_ALL;
         CLS_BRANCH: kind_o = DK_BR;
         default:    kind_o = DK_ANY;   // plain and unused codes
      endcase
   end

endmodule

// File: rtl/dgf_lane.sv
module dgf_lane
   import dgf_pkg::*;
#(
   parameter  int NB_SLOTS = 4,
   parameter  int BR_SLOTS = 2,
   localparam int NB_W     = $clog2(NB_SLOTS + 1),
   localparam int BR_W     = $clog2(BR_SLOTS + 1)
) (
   input  logic            vld_i,
   input  dk_e             kind_i,
   input  logic            open_i,
   input  logic [NB_W-1:0] nb_i,
   input  logic [BR_W-1:0] br_i,
   output logic            take_o,
   output logic            open_o,
   output logic [NB_W-1:0] nb_o,
   output logic [BR_W-1:0] br_o,
   output logic [NB_W-1:0] nb_base_o,
   output logic [NB_W-1:0] nb_cnt_o,
   output logic [BR_W-1:0] br_pos_o,
   output logic            is_br_o
);

   localparam logic [NB_W-1:0] NB_MAX  = NB_W'(NB_SLOTS);
   localparam logic [BR_W-1:0] BR_MAX  = BR_W'(BR_SLOTS);
   localparam logic [BR_W-1:0] BR_LAST = BR_W'(BR_SLOTS - 1);

   logic            fits;
   logic [NB_W-1:0] need;
   logic            nb_empty;

   assign nb_empty = (nb_i == '0);

   always_comb begin
      fits = 1'b0;
      need = '0;
      case (kind_i)
         DK_ANY:  begin fits = (nb_i < NB_MAX); need = NB_W'(1); end
         DK_HEAD: begin fits = nb_empty;        need = NB_W'(1); end
         DK_PAIR: begin fits = nb_empty;        need = NB_W'(2); end
         DK_ALL:  begin fits = nb_empty;        need = NB_MAX;   end
         DK_BR:   begin fits = (br_i < BR_MAX); need = '0;       end
         default: begin fits = 1'b0;            need = '0;       end
      endcase
   end

   assign is_br_o   = (kind_i == DK_BR);
   assign take_o    = open_i & vld_i & fits;
   assign nb_o      = take_o ? NB_W'(nb_i + need) : nb_i;
   assign br_o      = (take_o && is_br_o) ? BR_W'(br_i + BR_W'(1)) : br_i;
   assign open_o    = take_o & ~(is_br_o & (br_i == BR_LAST));
   assign nb_base_o = nb_i;
   assign nb_cnt_o  = need;
   assign br_pos_o  = br_i;

endmodule

// File: rtl/dgf_slot_map.sv
module dgf_slot_map #(
   parameter  int WIN      = 6,
   parameter  int NB_SLOTS = 4,
   parameter  int BR_SLOTS = 2,
   localparam int NB_W     = $clog2(NB_SLOTS + 1),
   localparam int BR_W     = $clog2(BR_SLOTS + 1),
   localparam int SLOTS    = NB_SLOTS + BR_SLOTS,
   localparam int IDX_W    = $clog2(WIN)
) (
   input  logic [WIN-1:0]       take_i,
   input  logic [WIN-1:0]       is_br_i,
   input  logic [WIN*NB_W-1:0]  nb_base_i,
   input  logic [WIN*NB_W-1:0]  nb_cnt_i,
   input  logic [WIN*BR_W-1:0]  br_pos_i,
   output logic [SLOTS-1:0]     slot_vld_o,
   output logic [SLOTS*IDX_W-1:0] slot_idx_o
);

   for (genvar s = 0; s < NB_SLOTS; s++) begin : g_nb
      always_comb begin
         slot_vld_o[s] = 1'b0;
         slot_idx_o[s*IDX_W +: IDX_W] = '0;
         for (int l = 0; l < WIN; l++) begin
            if (take_i[l] && !is_br_i[l]
                && int'(nb_base_i[l*NB_W +: NB_W]) <= s
                && s < int'(nb_base_i[l*NB_W +: NB_W]) + int'(nb_cnt_i[l*NB_W +: NB_W])) begin
               slot_vld_o[s] = 1'b1;
               slot_idx_o[s*IDX_W +: IDX_W] = IDX_W'(l);
            end
         end
      end
   end

   for (genvar b = 0; b < BR_SLOTS; b++) begin : g_br
      always_comb begin
         slot_vld_o[NB_SLOTS+b] = 1'b0;
         slot_idx_o[(NB_SLOTS+b)*IDX_W +: IDX_W] = '0;
         for (int l = 0; l < WIN; l++) begin
            if (take_i[l] && is_br_i[l] && int'(br_pos_i[l*BR_W +: BR_W]) == b) begin
               slot_vld_o[NB_SLOTS+b] = 1'b1;
               slot_idx_o[(NB_SLOTS+b)*IDX_W +: IDX_W] = IDX_W'(l);
            end
         end
      end
   end

endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
   import dgf_pkg::*;
#(
   parameter  int WIN      = 6,
   parameter  int NB_SLOTS = 4,
   parameter  int BR_SLOTS = 2,
   localparam int SLOTS    = NB_SLOTS + BR_SLOTS,
   localparam int IDX_W    = $clog2(WIN),
   localparam int CNT_W    = $clog2(WIN + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIN-1:0]         win_valid,
   input  logic [WIN*CLS_W-1:0]   win_class,
   input  logic                   out_ready,
   output logic [CNT_W-1:0]       take_cnt,
   output logic                   grp_vld,
   output logic [CNT_W-1:0]       grp_size,
   output logic [SLOTS-1:0]       grp_slot_vld,
   output logic [SLOTS*IDX_W-1:0] grp_slot_idx
);

   localparam int NB_W = $clog2(NB_SLOTS + 1);
   localparam int BR_W = $clog2(BR_SLOTS + 1);

   // elaboration-time parameter checks
   if (NB_SLOTS < 2) begin : g_bad_nb
      $error("NB_SLOTS must be at least 2 for two-slot cracking");
   end
   if (BR_SLOTS < 1) begin : g_bad_br
      $error("BR_SLOTS must be at least 1");
   end
   if (WIN < 2) begin : g_bad_win
      $error("WIN must be at least 2");
   end

   logic [WIN:0]            open_c;
   logic [(WIN+1)*NB_W-1:0] nb_c;
   logic [(WIN+1)*BR_W-1:0] br_c;
   logic [WIN-1:0]          take;
   logic [WIN-1:0]          is_br;
   logic [WIN*NB_W-1:0]     nb_base;
   logic [WIN*NB_W-1:0]     nb_cnt;
   logic [WIN*BR_W-1:0]     br_pos;
   logic [SLOTS-1:0]        map_vld;
   logic [SLOTS*IDX_W-1:0]  map_idx;

   assign open_c[0]      = out_ready;
   assign nb_c[0 +: NB_W] = '0;
   assign br_c[0 +: BR_W] = '0;

   for (genvar i = 0; i < WIN; i++) begin : g_lane
      dk_e kind;

      dgf_class_decode i_dec (
         .cls_i  (win_class[i*CLS_W +: CLS_W]),
         .kind_o (kind)
      );

      dgf_lane #(
         .NB_SLOTS (NB_SLOTS),
         .BR_SLOTS (BR_SLOTS)
      ) i_lane (
         .vld_i     (win_valid[i]),
         .kind_i    (kind),
         .open_i    (open_c[i]),
         .nb_i      (nb_c[i*NB_W +: NB_W]),
         .br_i      (br_c[i*BR_W +: BR_W]),
         .take_o    (take[i]),
         .open_o    (open_c[i+1]),
         .nb_o      (nb_c[(i+1)*NB_W +: NB_W]),
         .br_o      (br_c[(i+1)*BR_W +: BR_W]),
         .nb_base_o (nb_base[i*NB_W +: NB_W]),
         .nb_cnt_o  (nb_cnt[i*NB_W +: NB_W]),
         .br_pos_o  (br_pos[i*BR_W +: BR_W]),
         .is_br_o   (is_br[i])
      );
   end

   dgf_slot_map #(
      .WIN      (WIN),
      .NB_SLOTS (NB_SLOTS),
      .BR_SLOTS (BR_SLOTS)
   ) i_map (
      .take_i     (take),
      .is_br_i    (is_br),
      .nb_base_i  (nb_base),
      .nb_cnt_i   (nb_cnt),
      .br_pos_i   (br_pos),
      .slot_vld_o (map_vld),
      .slot_idx_o (map_idx)
   );

   // taken lanes form a prefix, so the count is the population
   assign take_cnt = CNT_W'($countones(take));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_vld      <= 1'b0;
         grp_size     <= '0;
         grp_slot_vld <= '0;
         grp_slot_idx <= '0;
      end else begin
         grp_vld      <= |take;
         grp_size     <= take_cnt;
         grp_slot_vld <= map_vld;
         grp_slot_idx <= map_idx;
      end
   end

endmodule

// File: rtl/dgf_checker.sv
module dgf_checker #(
   parameter  int WIN      = 6,
   parameter  int NB_SLOTS = 4,
   parameter  int BR_SLOTS = 2,
   localparam int SLOTS    = NB_SLOTS + BR_SLOTS,
   localparam int IDX_W    = $clog2(WIN),
   localparam int CNT_W    = $clog2(WIN + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   out_ready,
   input logic [CNT_W-1:0]       take_cnt,
   input logic                   grp_vld,
   input logic [CNT_W-1:0]       grp_size,
   input logic [SLOTS-1:0]       grp_slot_vld,
   input logic [SLOTS*IDX_W-1:0] grp_slot_idx
);

   assert_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> take_cnt == '0);

   assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> !grp_vld);

   assert_size_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> grp_size == $past(take_cnt));

   assert_empty_desc_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_vld |-> (grp_slot_vld == '0 && grp_size == '0));

   assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_cnt <= CNT_W'(WIN));

   for (genvar s = 0; s + 1 < NB_SLOTS; s++) begin : g_nb
      assert_nb_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
         grp_slot_vld[s+1] |-> grp_slot_vld[s]);
      assert_nb_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
         grp_slot_vld[s+1] |->
            grp_slot_idx[(s+1)*IDX_W +: IDX_W] >= grp_slot_idx[s*IDX_W +: IDX_W]);
   end

   for (genvar b = 0; b + 1 < BR_SLOTS; b++) begin : g_br
      assert_br_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
         grp_slot_vld[NB_SLOTS+b+1] |-> grp_slot_vld[NB_SLOTS+b]);
      assert_br_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
         grp_slot_vld[NB_SLOTS+b+1] |->
            grp_slot_idx[(NB_SLOTS+b+1)*IDX_W +: IDX_W] >
            grp_slot_idx[(NB_SLOTS+b)*IDX_W +: IDX_W]);
   end

endmodule

bind dispatch_group_former dgf_checker #(
   .WIN      (WIN),
   .NB_SLOTS (NB_SLOTS),
   .BR_SLOTS (BR_SLOTS)
) i_dgf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_ready    (out_ready),
   .take_cnt     (take_cnt),
   .grp_vld      (grp_vld),
   .grp_size     (grp_size),
   .grp_slot_vld (grp_slot_vld),
   .grp_slot_idx (grp_slot_idx)
);

// File: tb/test_dispatch_group_former.sv
`timescale 1ns/1ps
module test_dispatch_group_former;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  win_valid = '0;
   logic [17:0] win_class = '0;
   logic        out_ready = 1'b0;
   logic [2:0]  take_cnt;
   logic        grp_vld;
   logic [2:0]  grp_size;
   logic [5:0]  grp_slot_vld;
   logic [17:0] grp_slot_idx;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int exp_cnt;
   bit exp_sv[6];
   int exp_si[6];

   always #5 clk = ~clk;

   dispatch_group_former i_dispatch_group_former (
      .clk          (clk),
      .rst_n        (rst_n),
      .win_valid    (win_valid),
      .win_class    (win_class),
      .out_ready    (out_ready),
      .take_cnt     (take_cnt),
      .grp_vld      (grp_vld),
      .grp_size     (grp_size),
      .grp_slot_vld (grp_slot_vld),
      .grp_slot_idx (grp_slot_idx)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected group from the requirements
   task automatic ref_form(input logic [5:0] v, input logic [17:0] c, input bit rdy);
      int nb = 0;
      int br = 0;
      bit open = rdy;
      exp_cnt = 0;
      for (int s = 0; s < 6; s++) begin exp_sv[s] = 0; exp_si[s] = 0; end
      for (int i = 0; i < 6; i++) begin
         logic [2:0] k;
         bit ok = 0;
         k = c[i*3 +: 3];
         if (open && v[i]) begin
            if (k == 3'd4) begin
               if (br < 2) begin
                  exp_sv[4+br] = 1; exp_si[4+br] = i; br++; ok = 1;
               end
            end else if (k == 3'd1) begin
               if (nb == 0) begin exp_sv[0] = 1; exp_si[0] = i; nb = 1; ok = 1; end
            end else if (k == 3'd2) begin
               if (nb == 0) begin
                  for (int s = 0; s < 2; s++) begin exp_sv[s] = 1; exp_si[s] = i; end
                  nb = 2; ok = 1;
               end
            end else if (k == 3'd3) begin
               if (nb == 0) begin
                  for (int s = 0; s < 4; s++) begin exp_sv[s] = 1; exp_si[s] = i; end
                  nb = 4; ok = 1;
               end
            end else begin
               if (nb < 4) begin exp_sv[nb] = 1; exp_si[nb] = i; nb++; ok = 1; end
            end
         end
         if (ok) begin
            exp_cnt++;
            if (k == 3'd4 && br == 2) open = 0;
         end else begin
            open = 0;
         end
      end
   endtask

   task automatic apply(input string req, input logic [5:0] v, input logic [17:0] c, input bit rdy);
      @(negedge clk);
      win_valid = v;
      win_class = c;
      out_ready = rdy;
      ref_form(v, c, rdy);
      #1;
      check(req, "take_cnt", int'(take_cnt), exp_cnt);
      @(posedge clk);
      #1;
      check(req, "grp_vld", int'(grp_vld), int'(exp_cnt != 0));
      check(req, "grp_size", int'(grp_size), exp_cnt);
      for (int s = 0; s < 6; s++) begin
         check(req, $sformatf("slot%0d_vld", s), int'(grp_slot_vld[s]), int'(exp_sv[s]));
         if (exp_sv[s])
            check(req, $sformatf("slot%0d_idx", s), int'(grp_slot_idx[s*3 +: 3]), exp_si[s]);
      end
   endtask

   function automatic logic [17:0] mk(input int c0, c1, c2, c3, c4, c5);
      return {3'(c5), 3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
   endfunction

   initial begin
      void'($urandom(32'h5EED_0C1A));
      repeat (3) @(posedge clk);
      #1;
      check("R1", "grp_vld in reset", int'(grp_vld), 0);
      check("R1", "grp_slot_vld in reset", int'(grp_slot_vld), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "grp_vld after reset", int'(grp_vld), 0);
      check("R1", "grp_size after reset", int'(grp_size), 0);

      apply("R4", 6'h3F, mk(0,0,0,0,0,0), 1);
      apply("R6", 6'h3F, mk(0,1,0,0,0,0), 1);
      apply("R6", 6'h3F, mk(1,0,0,0,0,4), 1);
      apply("R7", 6'h3F, mk(2,0,0,0,0,0), 1);
      apply("R7", 6'h3F, mk(0,2,0,0,4,4), 1);
      apply("R8", 6'h3F, mk(3,0,4,4,0,0), 1);
      apply("R8", 6'h3F, mk(3,4,4,0,0,0), 1);
      apply("R8", 6'h3F, mk(4,3,0,0,0,0), 1);
      apply("R5", 6'h3F, mk(4,0,4,0,0,0), 1);
      apply("R5", 6'h3F, mk(4,4,4,0,0,0), 1);
      apply("R5", 6'h3F, mk(0,0,0,0,4,4), 1);
      apply("R10", 6'h3F, mk(5,6,7,0,0,4), 1);
      apply("R3", 6'b111011, mk(0,0,0,0,0,0), 1);
      apply("R3", 6'b000000, mk(0,0,0,0,0,0), 1);
      apply("R2", 6'h3F, mk(0,4,0,0,0,0), 0);
      apply("R9", 6'h3F, mk(2,4,0,0,0,5), 1);

      for (int n = 0; n < 400; n++) begin
         logic [5:0]  v;
         logic [17:0] c;
         bit rdy;
         for (int i = 0; i < 6; i++) begin
            int r = $urandom_range(0, 9);
            int k;
            if (r <= 3) k = 0;
            else if (r == 4) k = 1;
            else if (r == 5) k = 2;
            else if (r == 6) k = 3;
            else if (r <= 8) k = 4;
            else k = $urandom_range(5, 7);
            c[i*3 +: 3] = 3'(k);
         end
         v = 6'h3F >> $urandom_range(0, 6);
         if ($urandom_range(0, 7) == 0) v[$urandom_range(0, 5)] = 1'b0;
         rdy = ($urandom_range(0, 9) != 0);
         apply("R3/R9", v, c, rdy);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule